// File: doc/BRIEF.md
# Rectangle Copy and Solid Fill Engine

This block is a small 2D drawing engine that works on a word-addressed video memory. Software programs its registers with surface offsets, pitches, coordinates, rectangle size, pixel datatype, a raster-operation code and a few control bits. A write to the start register then launches one operation. The operation either copies a source rectangle onto a destination rectangle or paints the destination rectangle with one solid colour. That colour is a brush colour or one of two palette entries.

For each surface, the engine picks either that surface's own base and pitch registers or a pair of shared default registers. In the alternate addressing mode it adds a display offset to the base and scales the pitch by the pixel size. It then checks that the whole rectangle fits inside memory, and rejects an out-of-range request in full. Pixels move through a valid/ready memory port in raster order, with each pixel occupying one memory word. When an operation ends, the engine advances the destination coordinates so that software can chain rectangles.

Top module: `blt_engine`

## Requirements
- R1: The register file has these word indices: 0 src offset, 1 src pitch, 2 dst offset, 3 dst pitch, 4 default offset, 5 default pitch, 6 src x, 7 src y, 8 dst x, 9 dst y, 10 width, 11 height, 12 datatype, 13 mix, 14 control, 15 brush colour, 16 display offset, 17 palette entry 0, 18 palette entry 1, and 19 start. A register write takes effect only in a cycle where `reg_ready` is high. `reg_ready` is low for the whole time `busy` is high, and no register changes from software while an operation runs. Reads of `reg_rdata` are combinational on `reg_addr`.
- R2: Bits 3:0 of the datatype register set the pixel size. Code 2 gives 8 bits, codes 3 and 4 give 16, code 5 gives 24 and code 6 gives 32. Any other code refuses the operation with `err` set.
- R3: Bits 23:16 of the mix register hold the raster code. 0xCC copies. 0xF0, 0x00 and 0xFF fill. Any other code makes no memory access, leaves the coordinates unchanged and sets `err`.
- R4: Control bit 0 set makes the source use its own offset and pitch registers, and bit 0 clear makes it use the default pair. Control bit 1 makes the same choice for the destination.
- R5: With control bit 2 set, display offset bits 26:0 are added to both bases, and each pitch is multiplied by the pixel size in bits.
- R6: The word stride is the pitch divided by 4 (floor). Pixel (x, y) of a surface lives at word base/4 + y·stride + x, taken modulo the memory word count.
- R7: An operation is refused with no write and `err` set when any surface it uses has a base at or above MEM_BYTES, or when base + x + (y + height)·stride·4 is at or above MEM_BYTES.
- R8: Code 0xF0 fills with the brush colour with its four bytes reversed. Code 0x00 fills with {palette 0[23:0], 8'hFF}, and code 0xFF fills with {palette 1[23:0], 8'hFF}.
- R9: After an accepted copy, dst x increases by the width and dst y increases by the height. After an accepted fill, only dst y increases by the height. Both wrap at 16 bits.
- R10: Pixels are handled left to right within a row, and rows top to bottom. A copy reads each pixel and then writes it before moving to the next pixel. `busy` stays high until after the last write is accepted, and `done` pulses for exactly one cycle per operation.
- R11: A width or height of zero ends the operation with no memory access, but the coordinates are still updated as in R9.
- R12: A memory request keeps its address, direction and data steady until `mem_ready` is high. Read data is taken in the cycle after the read is accepted.
- R13: `err` is cleared when an operation starts. It holds the outcome of the last operation until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write request |
| reg_addr | input | 5 | Register index for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_ready | output | 1 | High when a register write can be accepted |
| reg_rdata | output | 32 | Read data of the register at reg_addr |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid one cycle after an accepted read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation was refused or ignored |

## Verification
The assertions assume that the memory returns read data exactly one cycle after it accepts a read. They also assume that `mem_ready` may fall at any time without any protocol obligation on the memory side. The bench's memory model is built to that contract, and it drops `mem_ready` in roughly one cycle out of four to exercise stalls. The bench sends register traffic only through `reg_ready`. Random offsets, pitches and sizes are kept small, so operations of both kinds, in-range and out-of-range, occur often. Directed cases cover zero size, an unknown raster code and an unsupported datatype.

// File: rtl/blt_pkg.sv
package blt_pkg;
    localparam int CRD_W = 16;
    localparam int RA_W  = 5;

    localparam logic [7:0] ROP_COPY  = 8'hCC;
    localparam logic [7:0] ROP_BRUSH = 8'hF0;
    localparam logic [7:0] ROP_BLACK = 8'h00;
    localparam logic [7:0] ROP_WHITE = 8'hFF;

    localparam logic [RA_W-1:0] IX_SOFF  = 5'd0;
    localparam logic [RA_W-1:0] IX_SPIT  = 5'd1;
    localparam logic [RA_W-1:0] IX_DOFF  = 5'd2;
    localparam logic [RA_W-1:0] IX_DPIT  = 5'd3;
    localparam logic [RA_W-1:0] IX_FOFF  = 5'd4;
    localparam logic [RA_W-1:0] IX_FPIT  = 5'd5;
    localparam logic [RA_W-1:0] IX_SX    = 5'd6;
    localparam logic [RA_W-1:0] IX_SY    = 5'd7;
    localparam logic [RA_W-1:0] IX_DX    = 5'd8;
    localparam logic [RA_W-1:0] IX_DY    = 5'd9;
    localparam logic [RA_W-1:0] IX_W     = 5'd10;
    localparam logic [RA_W-1:0] IX_H     = 5'd11;
    localparam logic [RA_W-1:0] IX_DT    = 5'd12;
    localparam logic [RA_W-1:0] IX_MIX   = 5'd13;
    localparam logic [RA_W-1:0] IX_CTL   = 5'd14;
    localparam logic [RA_W-1:0] IX_BRUSH = 5'd15;
    localparam logic [RA_W-1:0] IX_DISP  = 5'd16;
    localparam logic [RA_W-1:0] IX_PAL0  = 5'd17;
    localparam logic [RA_W-1:0] IX_PAL1  = 5'd18;
    localparam logic [RA_W-1:0] IX_GO    = 5'd19;

    typedef struct packed {
        logic [31:0]      src_off;
        logic [31:0]      src_pitch;
        logic [31:0]      dst_off;
        logic [31:0]      dst_pitch;
        logic [31:0]      def_off;
        logic [31:0]      def_pitch;
        logic [CRD_W-1:0] src_x;
        logic [CRD_W-1:0] src_y;
        logic [CRD_W-1:0] dst_x;
        logic [CRD_W-1:0] dst_y;
        logic [CRD_W-1:0] width;
        logic [CRD_W-1:0] height;
        logic [3:0]       dtype;
        logic [7:0]       rop;
        logic             src_own;
        logic             dst_own;
        logic             alt;
        logic [31:0]      brush;
        logic [31:0]      disp;
        logic [23:0]      pal0;
        logic [23:0]      pal1;
    } blt_cfg_t;

    typedef enum logic [2:0] {S_IDLE, S_RD, S_CAP, S_WR, S_DONE} wstate_e;

    function automatic logic [5:0] bpp_of(input logic [3:0] code);
        case (code)
            4'd2:       return 6'd8;
            4'd3, 4'd4: return 6'd16;
            4'd5:       return 6'd24;
            4'd6:       return 6'd32;
            default:    return 6'd0;
        endcase
    endfunction
endpackage

// File: rtl/blt_regs.sv
module blt_regs
    import blt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [RA_W-1:0] addr,
    input  logic [31:0]     wdata,
    input  logic            upd,
    input  logic            upd_copy,
    input  logic            busy,
    output blt_cfg_t        cfg,
    output logic [31:0]     rdata
);
    blt_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (addr)
                IX_SOFF:  cfg_d.src_off   = wdata;
                IX_SPIT:  cfg_d.src_pitch = wdata;
                IX_DOFF:  cfg_d.dst_off   = wdata;
                IX_DPIT:  cfg_d.dst_pitch = wdata;
                IX_FOFF:  cfg_d.def_off   = wdata;
                IX_FPIT:  cfg_d.def_pitch = wdata;
                IX_SX:    cfg_d.src_x     = wdata[CRD_W-1:0];
                IX_SY:    cfg_d.src_y     = wdata[CRD_W-1:0];
                IX_DX:    cfg_d.dst_x     = wdata[CRD_W-1:0];
                IX_DY:    cfg_d.dst_y     = wdata[CRD_W-1:0];
                IX_W:     cfg_d.width     = wdata[CRD_W-1:0];
                IX_H:     cfg_d.height    = wdata[CRD_W-1:0];
                IX_DT:    cfg_d.dtype     = wdata[3:0];
                IX_MIX:   cfg_d.rop       = wdata[23:16];
                IX_CTL:   {cfg_d.alt, cfg_d.dst_own, cfg_d.src_own} = wdata[2:0];
                IX_BRUSH: cfg_d.brush     = wdata;
                IX_DISP:  cfg_d.disp      = wdata;
                IX_PAL0:  cfg_d.pal0      = wdata[23:0];
                IX_PAL1:  cfg_d.pal1      = wdata[23:0];
                default:  ;
            endcase
        end
        if (upd) begin
            cfg_d.dst_y = cfg_q.dst_y + cfg_q.height;
            if (upd_copy) cfg_d.dst_x = cfg_q.dst_x + cfg_q.width;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        case (addr)
            IX_SOFF:  rdata = cfg_q.src_off;
            IX_SPIT:  rdata = cfg_q.src_pitch;
            IX_DOFF:  rdata = cfg_q.dst_off;
            IX_DPIT:  rdata = cfg_q.dst_pitch;
            IX_FOFF:  rdata = cfg_q.def_off;
            IX_FPIT:  rdata = cfg_q.def_pitch;
            IX_SX:    rdata = {16'd0, cfg_q.src_x};
            IX_SY:    rdata = {16'd0, cfg_q.src_y};
            IX_DX:    rdata = {16'd0, cfg_q.dst_x};
            IX_DY:    rdata = {16'd0, cfg_q.dst_y};
            IX_W:     rdata = {16'd0, cfg_q.width};
            IX_H:     rdata = {16'd0, cfg_q.height};
            IX_DT:    rdata = {28'd0, cfg_q.dtype};
            IX_MIX:   rdata = {8'd0, cfg_q.rop, 16'd0};
            IX_CTL:   rdata = {29'd0, cfg_q.alt, cfg_q.dst_own, cfg_q.src_own};
            IX_BRUSH: rdata = cfg_q.brush;
            IX_DISP:  rdata = cfg_q.disp;
            IX_PAL0:  rdata = {8'd0, cfg_q.pal0};
            IX_PAL1:  rdata = {8'd0, cfg_q.pal1};
            default:  rdata = 32'd0;
        endcase
    end

    assign cfg = cfg_q;

    // R1
    regs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg_q));
endmodule

// File: rtl/blt_setup.sv
module blt_setup
    import blt_pkg::*;
#(
    parameter int MEM_BYTES = 4096,
    parameter int ADDR_W    = 10
)(
    input  blt_cfg_t          cfg,
    output logic              is_copy,
    output logic              refuse,
    output logic [ADDR_W-1:0] src_word,
    output logic [ADDR_W-1:0] dst_word,
    output logic [ADDR_W-1:0] src_str,
    output logic [ADDR_W-1:0] dst_str,
    output logic [31:0]       fill
);
    localparam logic [63:0] LIMIT = 64'(MEM_BYTES);

    logic [5:0]  bpp;
    logic        rop_fill, rop_ok, oob_s, oob_d;
    logic [63:0] disp_m, s_base, d_base, s_pitch, d_pitch, s_stride, d_stride;
    logic [63:0] s_end, d_end, s_word, d_word;

    always_comb begin
        bpp      = bpp_of(cfg.dtype);
        is_copy  = (cfg.rop == ROP_COPY);
        rop_fill = (cfg.rop == ROP_BRUSH) || (cfg.rop == ROP_BLACK) || (cfg.rop == ROP_WHITE);
        rop_ok   = is_copy || rop_fill;

        disp_m  = cfg.alt ? {37'd0, cfg.disp[26:0]} : 64'd0;
        s_base  = {32'd0, (cfg.src_own ? cfg.src_off : cfg.def_off)} + disp_m;
        d_base  = {32'd0, (cfg.dst_own ? cfg.dst_off : cfg.def_off)} + disp_m;
        s_pitch = {32'd0, (cfg.src_own ? cfg.src_pitch : cfg.def_pitch)};
        d_pitch = {32'd0, (cfg.dst_own ? cfg.dst_pitch : cfg.def_pitch)};
        if (cfg.alt) begin
            s_pitch = s_pitch * {58'd0, bpp};
            d_pitch = d_pitch * {58'd0, bpp};
        end
        s_stride = s_pitch >> 2;
        d_stride = d_pitch >> 2;

        s_end = s_base + {48'd0, cfg.src_x}
              + ({48'd0, cfg.src_y} + {48'd0, cfg.height}) * s_stride * 64'd4;
        d_end = d_base + {48'd0, cfg.dst_x}
              + ({48'd0, cfg.dst_y} + {48'd0, cfg.height}) * d_stride * 64'd4;
        oob_s = is_copy && ((s_base >= LIMIT) || (s_end >= LIMIT));
        oob_d = (d_base >= LIMIT) || (d_end >= LIMIT);
        refuse = !rop_ok || (bpp == 6'd0) || oob_s || oob_d;

        s_word = (s_base >> 2) + {48'd0, cfg.src_y} * s_stride + {48'd0, cfg.src_x};
        d_word = (d_base >> 2) + {48'd0, cfg.dst_y} * d_stride + {48'd0, cfg.dst_x};
        src_word = s_word[ADDR_W-1:0];
        dst_word = d_word[ADDR_W-1:0];
        src_str  = s_stride[ADDR_W-1:0];
        dst_str  = d_stride[ADDR_W-1:0];

        case (cfg.rop)
            ROP_BLACK: fill = {cfg.pal0, 8'hFF};
            ROP_WHITE: fill = {cfg.pal1, 8'hFF};
            default:   fill = {cfg.brush[7:0], cfg.brush[15:8], cfg.brush[23:16], cfg.brush[31:24]};
        endcase
    end
endmodule

// File: rtl/blt_walker.sv
module blt_walker
    import blt_pkg::*;
#(
    parameter int ADDR_W = 10
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_copy,
    input  logic              refuse,
    input  logic [CRD_W-1:0]  width,
    input  logic [CRD_W-1:0]  height,
    input  logic [ADDR_W-1:0] src_word,
    input  logic [ADDR_W-1:0] dst_word,
    input  logic [ADDR_W-1:0] src_str,
    input  logic [ADDR_W-1:0] dst_str,
    input  logic [31:0]       fill,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              upd,
    output logic              upd_copy
);
    typedef struct packed {
        wstate_e           st;
        logic [ADDR_W-1:0] sa;
        logic [ADDR_W-1:0] da;
        logic [ADDR_W-1:0] sa_row;
        logic [ADDR_W-1:0] da_row;
        logic [CRD_W-1:0]  xc;
        logic [CRD_W-1:0]  yc;
        logic [31:0]       data;
        logic              err;
        logic              copy;
    } walk_t;

    walk_t w_d, w_q;
    logic  last_x, last_y;

    always_comb begin
        w_d       = w_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        last_x    = (w_q.xc == width - 16'd1);
        last_y    = (w_q.yc == height - 16'd1);
        case (w_q.st)
            S_IDLE: if (start) begin
                w_d.err    = 1'b0;
                w_d.copy   = is_copy;
                w_d.sa     = src_word;
                w_d.sa_row = src_word;
                w_d.da     = dst_word;
                w_d.da_row = dst_word;
                w_d.xc     = '0;
                w_d.yc     = '0;
                if (refuse) begin
                    w_d.err = 1'b1;
                    w_d.st  = S_DONE;
                end else if (width == '0 || height == '0) begin
                    w_d.st = S_DONE;
                end else begin
                    w_d.st = is_copy ? S_RD : S_WR;
                end
            end
            S_RD: begin
                mem_req  = 1'b1;
                mem_addr = w_q.sa;
                if (mem_ready) w_d.st = S_CAP;
            end
            S_CAP: begin
                w_d.data = mem_rdata;
                w_d.st   = S_WR;
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = w_q.da;
                mem_wdata = w_q.copy ? w_q.data : fill;
                if (mem_ready) begin
                    w_d.st = w_q.copy ? S_RD : S_WR;
                    if (!last_x) begin
                        w_d.xc = w_q.xc + 16'd1;
                        w_d.sa = w_q.sa + 1'b1;
                        w_d.da = w_q.da + 1'b1;
                    end else if (last_y) begin
                        w_d.st = S_DONE;
                    end else begin
                        w_d.xc     = '0;
                        w_d.yc     = w_q.yc + 16'd1;
                        w_d.sa_row = w_q.sa_row + src_str;
                        w_d.da_row = w_q.da_row + dst_str;
                        w_d.sa     = w_q.sa_row + src_str;
                        w_d.da     = w_q.da_row + dst_str;
                    end
                end
            end
            S_DONE:  w_d.st = S_IDLE;
            default: w_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '{st: S_IDLE, default: '0};
        else        w_q <= w_d;
    end

    assign busy     = (w_q.st != S_IDLE);
    assign done     = (w_q.st == S_DONE);
    assign err      = w_q.err;
    assign upd      = done && !w_q.err;
    assign upd_copy = w_q.copy;

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    req_in_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (busy && !done));
    // R7
    no_access_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !err);
    // R13
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !refuse) |=> !err);
endmodule

// File: rtl/blt_engine.sv
module blt_engine
    import blt_pkg::*;
#(
    parameter int MEM_BYTES = 4096,
    localparam int ADDR_W   = $clog2(MEM_BYTES / 4)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [4:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              reg_ready,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              err
);
    blt_cfg_t          cfg;
    logic              wr_acc, start, upd, upd_copy, is_copy, refuse;
    logic [ADDR_W-1:0] src_word, dst_word, src_str, dst_str;
    logic [31:0]       fill;

    assign reg_ready = !busy;
    assign wr_acc    = reg_we && reg_ready;
    assign start     = wr_acc && (reg_addr == IX_GO);

    blt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_acc), .addr(reg_addr), .wdata(reg_wdata),
        .upd(upd), .upd_copy(upd_copy), .busy(busy), .cfg(cfg), .rdata(reg_rdata)
    );

    blt_setup #(.MEM_BYTES(MEM_BYTES), .ADDR_W(ADDR_W)) u_setup (
        .cfg(cfg), .is_copy(is_copy), .refuse(refuse), .src_word(src_word),
        .dst_word(dst_word), .src_str(src_str), .dst_str(dst_str), .fill(fill)
    );

    blt_walker #(.ADDR_W(ADDR_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .start(start), .is_copy(is_copy), .refuse(refuse),
        .width(cfg.width), .height(cfg.height), .src_word(src_word), .dst_word(dst_word),
        .src_str(src_str), .dst_str(dst_str), .fill(fill),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .err(err), .upd(upd), .upd_copy(upd_copy)
    );

    // R1
    ready_vs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !reg_ready);
endmodule

// File: tb/blt_engine_tb.sv
`timescale 1ns/1ps
module blt_engine_tb;
    localparam int MB = 4096;
    localparam int MW = MB / 4;

    logic        clk = 0, rst_n = 0;
    logic        reg_we = 0;
    logic [4:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic        reg_ready, mem_req, mem_we, busy, done, err;
    logic [31:0] reg_rdata, mem_wdata;
    logic [9:0]  mem_addr;
    logic        mem_ready = 1;
    logic [31:0] mem_rdata = 0;

    logic [31:0] mem [MW];
    logic [31:0] expm [MW];
    int checks = 0, fails = 0, wr_cnt = 0, done_cnt = 0, cycles = 0;

    logic [31:0] b_soff, b_spit, b_doff, b_dpit, b_foff, b_fpit, b_brush, b_disp;
    logic [15:0] b_sx, b_sy, b_dx, b_dy, b_w, b_h;
    logic [3:0]  b_dt;
    logic [7:0]  b_rop;
    logic [2:0]  b_ctl;
    logic [23:0] b_p0, b_p1;

    always #2.5 clk = ~clk;

    blt_engine u_dut (.*);

    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            if (mem_we) begin mem[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
            else mem_rdata <= mem[mem_addr];
        end
    end
    always @(negedge clk) begin
        mem_ready = ($urandom % 4) != 0;
        if (done) done_cnt++;
        cycles++;
        if (busy && reg_ready) begin
            checks++; fails++;
            $display("FAIL R1: reg_ready=%0b expected 0 while busy", reg_ready);
        end
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected < 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        while (!reg_ready) @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic load_all();
        wr(0, b_soff); wr(1, b_spit); wr(2, b_doff); wr(3, b_dpit);
        wr(4, b_foff); wr(5, b_fpit); wr(6, {16'd0, b_sx}); wr(7, {16'd0, b_sy});
        wr(8, {16'd0, b_dx}); wr(9, {16'd0, b_dy}); wr(10, {16'd0, b_w});
        wr(11, {16'd0, b_h}); wr(12, {28'd0, b_dt}); wr(13, {8'd0, b_rop, 16'd0});
        wr(14, {29'd0, b_ctl}); wr(15, b_brush); wr(16, b_disp);
        wr(17, {8'd0, b_p0}); wr(18, {8'd0, b_p1});
    endtask

    function automatic int bpp_f(input logic [3:0] c);
        case (c) 2: return 8; 3, 4: return 16; 5: return 24; 6: return 32; default: return 0; endcase
    endfunction

    // bench model of one operation on expm; returns expected err and write count
    task automatic model(output bit e_err, output int e_wr);
        longint unsigned sb, db, sp, dp, ss, ds, se, de;
        int bpp; bit cp, fl; logic [31:0] colour;
        bpp = bpp_f(b_dt);
        cp = (b_rop == 8'hCC);
        fl = (b_rop == 8'hF0) || (b_rop == 8'h00) || (b_rop == 8'hFF);
        sb = b_ctl[0] ? b_soff : b_foff; sp = b_ctl[0] ? b_spit : b_fpit;
        db = b_ctl[1] ? b_doff : b_foff; dp = b_ctl[1] ? b_dpit : b_fpit;
        if (b_ctl[2]) begin
            sb += b_disp & 32'h07FF_FFFF; db += b_disp & 32'h07FF_FFFF;
            sp *= bpp; dp *= bpp;
        end
        ss = sp >> 2; ds = dp >> 2;
        se = sb + b_sx + (longint'(b_sy) + b_h) * ss * 4;
        de = db + b_dx + (longint'(b_dy) + b_h) * ds * 4;
        e_err = !(cp || fl) || bpp == 0 || db >= MB || de >= MB || (cp && (sb >= MB || se >= MB));
        e_wr = 0;
        if (e_err) return;
        colour = (b_rop == 8'h00) ? {b_p0, 8'hFF} : (b_rop == 8'hFF) ? {b_p1, 8'hFF}
               : {b_brush[7:0], b_brush[15:8], b_brush[23:16], b_brush[31:24]};
        for (int y = 0; y < int'(b_h); y++)
            for (int x = 0; x < int'(b_w); x++) begin
                int si, di;
                si = int'(((sb >> 2) + (b_sy + y) * ss + b_sx + x) % MW);
                di = int'(((db >> 2) + (b_dy + y) * ds + b_dx + x) % MW);
                expm[di] = cp ? expm[si] : colour;
                e_wr++;
            end
        if (cp) b_dx = b_dx + b_w;
        b_dy = b_dy + b_h;
    endtask

    task automatic run_op(input string tag);
        bit e_err; int e_wr, mis; logic [31:0] v;
        load_all();
        for (int i = 0; i < MW; i++) expm[i] = mem[i];
        model(e_err, e_wr);
        wr_cnt = 0; done_cnt = 0;
        wr(19, 0);
        while (busy) @(negedge clk);
        @(negedge clk);
        mis = 0;
        for (int i = 0; i < MW; i++) if (mem[i] !== expm[i]) mis++;
        chk({tag, " R6 R8 R10 memory mismatches"}, mis, 0);
        chk({tag, " R7 R13 err"}, {31'd0, err}, {31'd0, e_err});
        chk({tag, " R10 write count"}, wr_cnt, e_wr);
        chk({tag, " R10 done pulses"}, done_cnt, 1);
        rd(8, v); chk({tag, " R9 dst_x"}, v, {16'd0, b_dx});
        rd(9, v); chk({tag, " R9 dst_y"}, v, {16'd0, b_dy});
    endtask

    task automatic base_cfg();
        b_soff = 0; b_spit = 128; b_doff = 2048; b_dpit = 128; b_foff = 1024; b_fpit = 64;
        b_sx = 1; b_sy = 2; b_dx = 3; b_dy = 1; b_w = 4; b_h = 3; b_dt = 6;
        b_rop = 8'hCC; b_ctl = 3'b011; b_brush = 32'h1122_3344; b_disp = 0;
        b_p0 = 24'h000001; b_p1 = 24'hFFFFFE;
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd7321));
        for (int i = 0; i < MW; i++) mem[i] = $urandom;
        #12 rst_n = 1;
        @(negedge clk);
        chk("R1 reset busy", {31'd0, busy}, 0);
        chk("R1 reset ready", {31'd0, reg_ready}, 1);
        chk("R13 reset err", {31'd0, err}, 0);
        chk("R12 reset req", {31'd0, mem_req}, 0);
        rd(8, v); chk("R1 reset dst_x", v, 0);

        base_cfg(); run_op("R3 R4 copy own");
        base_cfg(); b_rop = 8'hF0; run_op("R8 brush fill");
        base_cfg(); b_rop = 8'h00; b_ctl = 3'b000; run_op("R4 R8 black default");
        base_cfg(); b_rop = 8'hFF; run_op("R8 white");
        base_cfg(); b_w = 0; run_op("R11 zero width copy");
        base_cfg(); b_rop = 8'hF0; b_h = 0; run_op("R11 zero height fill");
        base_cfg(); b_rop = 8'h5A; run_op("R3 unknown rop");
        base_cfg(); b_dt = 4'd7; run_op("R2 bad datatype");
        base_cfg(); b_dt = 4'd2; b_ctl = 3'b111; b_spit = 16; b_dpit = 16; b_disp = 32'hF800_0010;
        run_op("R2 R5 alt 8bpp");
        base_cfg(); b_doff = 4000; run_op("R7 dst bound");
        base_cfg(); b_soff = 5000; run_op("R7 src base");
        base_cfg(); b_rop = 8'hF0; b_soff = 5000; run_op("R7 fill ignores src");

        for (int n = 0; n < 60; n++) begin
            logic [7:0] rops [5];
            rops = '{8'hCC, 8'hF0, 8'h00, 8'hFF, 8'h66};
            b_soff = $urandom % 2048; b_doff = $urandom % 2048; b_foff = $urandom % 2048;
            b_ctl = 3'($urandom);
            if (b_ctl[2]) begin
                b_spit = 8 + $urandom % 9; b_dpit = 8 + $urandom % 9; b_fpit = 8 + $urandom % 9;
            end else begin
                b_spit = 64 + 4 * ($urandom % 48); b_dpit = 64 + 4 * ($urandom % 48);
                b_fpit = 64 + 4 * ($urandom % 48);
            end
            b_sx = $urandom % 8; b_sy = $urandom % 8; b_dx = $urandom % 8; b_dy = $urandom % 8;
            b_w = $urandom % 7; b_h = $urandom % 7;
            b_dt = 2 + $urandom % 5; if ($urandom % 10 == 0) b_dt = 4'd9;
            b_rop = rops[$urandom % 5]; b_brush = $urandom; b_disp = $urandom % 256;
            b_p0 = 24'($urandom); b_p1 = 24'($urandom);
            run_op("R4 R5 R6 R9 R12 random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule